// File: doc/BRIEF.md
# Master-Slave Multi-Output PWM Timer

This block groups one master channel and two slave channels into a single timer. The master repeatedly counts out a programmable period. Each time it wraps, it fires a start pulse that restarts both slaves together. From its own duty register, each slave then drives its active level for a set number of count ticks, and the inactive level for the rest of the period. The result is two independent duty cycles on one shared period.

Software controls the group through a write-only register port. A unit-enable register gates every other write and all counting. A clock-select register picks one of two prescaled count rates. A run bit starts and stops the group. Other registers hold the period, the two duties, and a packed output-configuration word. That word has four fields, each two bits wide with bit i belonging to output i: slave mode at bits [1:0], polarity at [3:2], preset level at [5:4] and output enable at [7:6].

While the group is stopped, each output keeps its level. A configuration write made while stopped loads the preset level onto the output. An output whose enable bit is clear reports a high-impedance pin.

The master sequencer has three states. ST_OFF is the unit disabled. ST_IDLE is enabled and stopped. ST_RUN is counting. Its transitions are as follows:
- ST_OFF to ST_IDLE happens when the unit is enabled.
- ST_IDLE to ST_RUN happens on the first start pulse.
- ST_RUN to ST_IDLE happens when run clears.
- Any state goes to ST_OFF when the unit enable clears.

Each slave has three states. SL_HELD means it is not generating. SL_ON is the active phase. SL_OFF is the inactive phase. Its transitions are as follows:
- A start pulse moves it to SL_ON, or to SL_OFF when the duty is zero.
- On a tick in SL_ON whose remaining count is 1, it moves from SL_ON to SL_OFF.
- Leaving ST_RUN, or clearing the mode bit, moves it to SL_HELD.

Top module: `pwm_group`

## Requirements
- R1: While the unit is disabled (address 0, bit 0 = 0), writes to every other address are ignored and no counting or output change takes place. Writing 0 to address 0 also clears the run bit.
- R2: With run set (address 2, bit 0), the first start pulse comes on the first count tick. After that, a start pulse comes every PER+1 ticks, where PER is the period register (address 4).
- R3: A slave in slave mode is at its active level for the first D ticks of each period, where D is its duty register (address 5 for output 0, address 6 for output 1). D = 0 keeps the output inactive.
- R4: A duty value greater than PER keeps the output at its active level for the whole period.
- R5: Polarity bit i (configuration bits [3:2]) at 0 makes the active level high. At 1 it makes the active level low.
- R6: An output whose mode bit (configuration bits [1:0]) is 0 does not toggle while running. It holds its level.
- R7: A configuration write (address 3) accepted while not running puts preset bit i (configuration bits [5:4]) onto output i on the following cycle.
- R8: pwm_hiz[i] is 1 while enable bit i (configuration bits [7:6]) is 0, and 0 once that bit is set. After reset all outputs are low and all report high-impedance.
- R9: Clearing run stops the group. The outputs then keep their last level with no toggling.
- R10: Period and duty writes made while running take effect only from the next start pulse. This includes a write landing on the same edge as a start pulse.
- R11: With clock select (address 1, bit 0) at 0, a count tick comes every 2^SHIFT_A cycles. At 1, it comes every 2^SHIFT_B cycles. The prescaler restarts when the unit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DW | Register write data |
| pwm_out | output | NOUT | Output levels, one bit per slave |
| pwm_hiz | output | NOUT | 1 where the output pin reports high-impedance |

## Verification
A register write can land on the same clock edge as a master wrap. The write then competes with the start pulse, which latches period and duty. The bench provokes this by watching its reference model until the master count sits at zero with a tick due. It then drives a period or duty write in that exact cycle. The check is that the period beginning at that edge still uses the old values, and that the new ones appear only at the following wrap.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_RUN
    } grp_state_e;

    typedef enum logic [1:0] {
        SL_HELD,
        SL_ON,
        SL_OFF
    } sl_state_e;

    localparam int A_UNIT   = 0;
    localparam int A_CLKSEL = 1;
    localparam int A_RUN    = 2;
    localparam int A_OUTCFG = 3;
    localparam int A_PERIOD = 4;
    localparam int A_DUTY0  = 5;

endpackage

// File: rtl/pwm_grp_regs.sv
module pwm_grp_regs
    import pwm_grp_pkg::*;
#(
    parameter int NOUT   = 2,
    parameter int DW     = 16,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic                      unit_en,
    output logic                      clk_sel,
    output logic                      run,
    output logic [DW-1:0]             period,
    output logic [NOUT-1:0][DW-1:0]   duty,
    output logic [NOUT-1:0]           mode,
    output logic [NOUT-1:0]           pol,
    output logic [NOUT-1:0]           oen,
    output logic                      cfg_wr,
    output logic [NOUT-1:0]           def_new
);

    localparam int CFG_W = 4 * NOUT;

    logic              accept;
    logic [CFG_W-1:0]  cfg_q;

    assign accept  = wr_en && (unit_en || (wr_addr == ADDR_W'(A_UNIT)));
    assign cfg_wr  = accept && (wr_addr == ADDR_W'(A_OUTCFG));
    assign def_new = wr_data[3*NOUT-1:2*NOUT];

    assign mode = cfg_q[NOUT-1:0];
    assign pol  = cfg_q[2*NOUT-1:NOUT];
    assign oen  = cfg_q[4*NOUT-1:3*NOUT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_en <= 1'b0;
            clk_sel <= 1'b0;
            run     <= 1'b0;
            period  <= '0;
            cfg_q   <= '0;
        end else if (accept) begin
            if (wr_addr == ADDR_W'(A_UNIT)) begin
                unit_en <= wr_data[0];
                if (!wr_data[0]) begin
                    run <= 1'b0;
                end
            end
            if (wr_addr == ADDR_W'(A_CLKSEL)) begin
                clk_sel <= wr_data[0];
            end
            if (wr_addr == ADDR_W'(A_RUN)) begin
                run <= wr_data[0];
            end
            if (wr_addr == ADDR_W'(A_OUTCFG)) begin
                cfg_q <= wr_data[CFG_W-1:0];
            end
            if (wr_addr == ADDR_W'(A_PERIOD)) begin
                period <= wr_data;
            end
        end
    end

    for (genvar gi = 0; gi < NOUT; gi++) begin : g_duty
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                duty[gi] <= '0;
            end else if (accept && (wr_addr == ADDR_W'(A_DUTY0 + gi))) begin
                duty[gi] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pwm_grp_prescale.sv
module pwm_grp_prescale #(
    parameter int SHIFT_A = 0,
    parameter int SHIFT_B = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unit_en,
    input  logic clk_sel,
    output logic tick
);

    localparam int SHMAX = (SHIFT_A > SHIFT_B) ? SHIFT_A : SHIFT_B;
    localparam int DIVW  = SHMAX + 1;

    logic [DIVW-1:0] div_q;
    logic [1:0]      tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!unit_en) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    for (genvar gt = 0; gt < 2; gt++) begin : g_tap
        localparam int SH = (gt == 0) ? SHIFT_A : SHIFT_B;
        localparam logic [DIVW-1:0] MSK = DIVW'((1 << SH) - 1);
        assign tap[gt] = ((div_q & MSK) == MSK);
    end

    assign tick = unit_en && tap[clk_sel];

endmodule

// File: rtl/pwm_grp_master.sv
module pwm_grp_master
    import pwm_grp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unit_en,
    input  logic          run,
    input  logic          tick,
    input  logic [DW-1:0] period,
    output grp_state_e    state,
    output logic          start,
    output logic          step,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] lat_per
);

    grp_state_e state_d;
    logic       go;

    assign go = unit_en && run && tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF: begin
                if (unit_en) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!unit_en)   state_d = ST_OFF;
                else if (start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!unit_en)   state_d = ST_OFF;
                else if (!run)  state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs: start pulse at the wrap, step on every other tick
    always_comb begin
        start = 1'b0;
        step  = 1'b0;
        unique case (state)
            ST_OFF: begin
                start = 1'b0;
            end
            ST_IDLE: begin
                start = go;
            end
            ST_RUN: begin
                start = go && (cnt == '0);
                step  = go && (cnt != '0);
            end
            default: begin
                start = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            lat_per <= '0;
        end else if (start) begin
            cnt     <= period;
            lat_per <= period;
        end else if (step) begin
            cnt     <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/pwm_grp_slave.sv
module pwm_grp_slave
    import pwm_grp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    input  logic          grp_run,
    input  logic          mode,
    input  logic          pol,
    input  logic [DW-1:0] duty,
    input  logic          cfg_wr,
    input  logic          def_new,
    output logic          lvl
);

    sl_state_e sl_q;
    sl_state_e sl_d;
    logic [DW-1:0] rem;
    logic act;
    logic more;

    assign act  = ~pol;
    assign more = (rem > DW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl_q <= SL_HELD;
        end else begin
            sl_q <= sl_d;
        end
    end

    // next state
    always_comb begin
        sl_d = sl_q;
        if (start && mode) begin
            sl_d = (duty != '0) ? SL_ON : SL_OFF;
        end else if (!grp_run || !mode) begin
            sl_d = SL_HELD;
        end else if (step) begin
            unique case (sl_q)
                SL_HELD: sl_d = SL_HELD;
                SL_ON:   sl_d = more ? SL_ON : SL_OFF;
                SL_OFF:  sl_d = SL_OFF;
                default: sl_d = SL_HELD;
            endcase
        end
    end

    // remaining active ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (start && mode) begin
            rem <= duty;
        end else if (step && (rem != '0)) begin
            rem <= rem - 1'b1;
        end
    end

    // output level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= 1'b0;
        end else if (start && mode) begin
            lvl <= (duty != '0) ? act : ~act;
        end else if (step && mode) begin
            lvl <= ((sl_q == SL_ON) && more) ? act : ~act;
        end else if (cfg_wr && !grp_run) begin
            lvl <= def_new;
        end
    end

endmodule

// File: rtl/pwm_group.sv
module pwm_group
    import pwm_grp_pkg::*;
#(
    parameter int NOUT    = 2,
    parameter int DW      = 16,
    parameter int ADDR_W  = 4,
    parameter int SHIFT_A = 0,
    parameter int SHIFT_B = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NOUT-1:0]   pwm_out,
    output logic [NOUT-1:0]   pwm_hiz
);

    logic                    unit_en;
    logic                    clk_sel;
    logic                    run;
    logic [DW-1:0]           period;
    logic [NOUT-1:0][DW-1:0] duty;
    logic [NOUT-1:0]         mode;
    logic [NOUT-1:0]         pol;
    logic [NOUT-1:0]         oen;
    logic                    cfg_wr;
    logic [NOUT-1:0]         def_new;
    logic                    tick;
    grp_state_e              st;
    logic                    mst_start;
    logic                    mst_step;
    logic [DW-1:0]           mst_cnt;
    logic [DW-1:0]           mst_per;
    logic                    grp_run;

    pwm_grp_regs #(.NOUT(NOUT), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .unit_en (unit_en),
        .clk_sel (clk_sel),
        .run     (run),
        .period  (period),
        .duty    (duty),
        .mode    (mode),
        .pol     (pol),
        .oen     (oen),
        .cfg_wr  (cfg_wr),
        .def_new (def_new)
    );

    pwm_grp_prescale #(.SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .unit_en (unit_en),
        .clk_sel (clk_sel),
        .tick    (tick)
    );

    pwm_grp_master #(.DW(DW)) u_mst (
        .clk     (clk),
        .rst_n   (rst_n),
        .unit_en (unit_en),
        .run     (run),
        .tick    (tick),
        .period  (period),
        .state   (st),
        .start   (mst_start),
        .step    (mst_step),
        .cnt     (mst_cnt),
        .lat_per (mst_per)
    );

    assign grp_run = (st == ST_RUN);

    for (genvar gs = 0; gs < NOUT; gs++) begin : g_slave
        pwm_grp_slave #(.DW(DW)) u_slv (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (mst_start),
            .step    (mst_step),
            .grp_run (grp_run),
            .mode    (mode[gs]),
            .pol     (pol[gs]),
            .duty    (duty[gs]),
            .cfg_wr  (cfg_wr),
            .def_new (def_new[gs]),
            .lvl     (pwm_out[gs])
        );
    end

    assign pwm_hiz = ~oen;

endmodule

// File: rtl/pwm_group_chk.sv
module pwm_group_chk
    import pwm_grp_pkg::*;
#(
    parameter int NOUT = 2,
    parameter int DW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    unit_en,
    input  grp_state_e              st,
    input  logic                    mst_start,
    input  logic                    mst_step,
    input  logic [DW-1:0]           mst_cnt,
    input  logic [DW-1:0]           mst_per,
    input  logic [NOUT-1:0]         mode,
    input  logic [NOUT-1:0]         pol,
    input  logic [NOUT-1:0][DW-1:0] duty,
    input  logic [DW-1:0]           period,
    input  logic                    cfg_wr,
    input  logic [NOUT-1:0]         pwm_out
);

    AST_NO_COUNT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> $stable(mst_cnt)); // R1

    AST_START_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        mst_start |=> (st == ST_RUN)); // R2

    AST_CNT_WITHIN_PER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (mst_cnt <= mst_per)); // R2

    AST_PER_HELD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUN) && !mst_start) |=> $stable(mst_per)); // R10

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_RUN) && !mst_start && !cfg_wr) |=> $stable(pwm_out)); // R9

    for (genvar gc = 0; gc < NOUT; gc++) begin : g_chk
        AST_MODE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ((st == ST_RUN) && !mode[gc]) |=> $stable(pwm_out[gc])); // R6

        AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
            (mst_start && mode[gc] && (duty[gc] == '0) && !cfg_wr)
            |=> (pwm_out[gc] == pol[gc])); // R3

        AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
            (mst_start && mode[gc] && (duty[gc] > period) && !cfg_wr)
            |=> (pwm_out[gc] == !pol[gc])); // R4

        AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            mst_step |-> (st == ST_RUN)); // R2
    end

endmodule

bind pwm_group pwm_group_chk #(.NOUT(NOUT), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_en   (unit_en),
    .st        (st),
    .mst_start (mst_start),
    .mst_step  (mst_step),
    .mst_cnt   (mst_cnt),
    .mst_per   (mst_per),
    .mode      (mode),
    .pol       (pol),
    .duty      (duty),
    .period    (period),
    .cfg_wr    (cfg_wr),
    .pwm_out   (pwm_out)
);

// File: tb/pwm_group_tb.sv
module pwm_group_tb;

    localparam int NOUT = 2;
    localparam int DW   = 16;
    localparam int AW   = 4;
    localparam int SHA  = 0;
    localparam int SHB  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    pwm_out;
    logic [1:0]    pwm_hiz;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R8";
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_group #(.NOUT(NOUT), .DW(DW), .ADDR_W(AW), .SHIFT_A(SHA), .SHIFT_B(SHB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .pwm_hiz(pwm_hiz)
    );

    // ---------------- reference model (from the requirements) ----------------
    bit  m_unit, m_sel, m_run;
    int  m_per, m_cnt, m_k, m_div, m_st;
    int  m_d [2];
    int  m_ld [2];
    bit  [1:0] m_mode, m_pol, m_en, m_lvl;

    function automatic bit tick_due(int div, bit sel);
        int msk;
        msk = sel ? ((1 << SHB) - 1) : ((1 << SHA) - 1);
        return (div & msk) == msk;
    endfunction

    function automatic bit act_lvl(int k, int d, bit p);
        return (k < d) ? !p : p;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_unit = 0; m_sel = 0; m_run = 0; m_per = 0; m_cnt = 0; m_k = 0;
            m_div = 0; m_st = 0; m_mode = 0; m_pol = 0; m_en = 0; m_lvl = 0;
            m_d[0] = 0; m_d[1] = 0; m_ld[0] = 0; m_ld[1] = 0;
        end else begin : mdl
            bit tk, s_start, s_step, acc, cfgw, in_run;
            tk      = m_unit && tick_due(m_div, m_sel);
            in_run  = (m_st == 2);
            s_start = m_unit && m_run && tk && ((m_st == 1) || (in_run && m_cnt == 0));
            s_step  = m_unit && m_run && tk && in_run && (m_cnt != 0);
            acc     = wr_en && (m_unit || wr_addr == 0);
            cfgw    = acc && (wr_addr == 3);
            for (int i = 0; i < 2; i++) begin
                if (s_start && m_mode[i]) begin
                    m_ld[i] = m_d[i];
                    m_lvl[i] = act_lvl(0, m_d[i], m_pol[i]);
                end else if (s_step && m_mode[i]) begin
                    m_lvl[i] = act_lvl(m_k + 1, m_ld[i], m_pol[i]);
                end else if (cfgw && !in_run) begin
                    m_lvl[i] = wr_data[4 + i];
                end
            end
            if (s_start) m_k = 0; else if (s_step) m_k = m_k + 1;
            if (s_start) m_cnt = m_per; else if (s_step) m_cnt = m_cnt - 1;
            if (!m_unit) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else if (m_st == 1 && s_start) m_st = 2;
            else if (m_st == 2 && !m_run) m_st = 1;
            m_div = m_unit ? m_div + 1 : 0;
            if (acc) begin
                case (wr_addr)
                    0: begin m_unit = wr_data[0]; if (!wr_data[0]) m_run = 0; end
                    1: m_sel = wr_data[0];
                    2: m_run = wr_data[0];
                    3: begin m_mode = wr_data[1:0]; m_pol = wr_data[3:2]; m_en = wr_data[7:6]; end
                    4: m_per = int'(wr_data);
                    5: m_d[0] = int'(wr_data);
                    6: m_d[1] = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({pwm_out, pwm_hiz} === {m_lvl, ~m_en}, cur_req, "out/hiz vs model",
                  int'({pwm_out, pwm_hiz}), int'({m_lvl, ~m_en}));
        end
    end

    task automatic wr_now(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int cfg(bit [1:0] md, bit [1:0] pl, bit [1:0] df, bit [1:0] en);
        return int'({en, df, pl, md});
    endfunction

    // measures cycles between two rising edges of pwm_out[0]
    task automatic rise_gap(output int gap);
        int t;
        gap = -1;
        while (!(pwm_out[0] == 1'b0)) @(negedge clk);
        while (pwm_out[0] == 1'b0) @(negedge clk);
        t = 0;
        while (pwm_out[0] == 1'b1) begin @(negedge clk); t++; end
        while (pwm_out[0] == 1'b0) begin @(negedge clk); t++; end
        gap = t;
    endtask

    initial begin : wdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int gap, hold;
        process::self().srandom(32'h5eed1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(pwm_out == 2'b00 && pwm_hiz == 2'b11, "R8", "reset out/hiz",
              int'({pwm_out, pwm_hiz}), 3);

        // R1: writes ignored while unit off
        cur_req = "R1";
        wr(3, cfg(2'b11, 2'b00, 2'b11, 2'b11));
        wr(4, 3);
        wr(2, 1);
        idle(6);
        check(pwm_hiz == 2'b11 && pwm_out == 2'b00, "R1", "writes while disabled",
              int'({pwm_out, pwm_hiz}), 3);

        // enable unit; R8 enable; R7 preset levels
        wr(0, 1);
        cur_req = "R8";
        wr(3, cfg(2'b11, 2'b00, 2'b00, 2'b11));
        check(pwm_hiz == 2'b00, "R8", "hiz after enable", int'(pwm_hiz), 0);
        cur_req = "R7";
        wr(3, cfg(2'b11, 2'b00, 2'b01, 2'b11));
        check(pwm_out == 2'b01, "R7", "preset 01", int'(pwm_out), 1);
        wr(3, cfg(2'b11, 2'b00, 2'b10, 2'b01));
        check(pwm_out == 2'b10 && pwm_hiz == 2'b10, "R7", "preset 10 / hiz",
              int'({pwm_out, pwm_hiz}), 10);

        // R2/R3: period 6 ticks, duty 1 on output 0, duty 0 on output 1
        cur_req = "R3";
        wr(3, cfg(2'b11, 2'b00, 2'b00, 2'b11));
        wr(4, 5); wr(5, 1); wr(6, 0);
        wr(2, 1);
        rise_gap(gap);
        check(gap == 6, "R2", "period cycles", gap, 6);
        hold = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (pwm_out[1]) hold++; end
        check(hold == 0, "R3", "zero duty stays inactive", hold, 0);

        // R4: duty beyond period stays active
        cur_req = "R4";
        wr(6, 9);
        idle(8);
        hold = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (!pwm_out[1]) hold++; end
        check(hold == 0, "R4", "full duty stays active", hold, 0);

        // R9: stop holds levels
        cur_req = "R9";
        wr(2, 0);
        @(negedge clk);
        begin
            logic [1:0] snap;
            snap = pwm_out; hold = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out != snap) hold++; end
            check(hold == 0, "R9", "stopped outputs stable", hold, 0);
        end

        // R5 polarity, R6 mode 0 hold
        cur_req = "R5";
        wr(3, cfg(2'b11, 2'b11, 2'b00, 2'b11));
        wr(5, 2); wr(6, 0);
        wr(2, 1);
        idle(10);
        hold = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (!pwm_out[1]) hold++; end
        check(hold == 0, "R5", "active-low zero duty stays high", hold, 0);
        wr(2, 0);
        cur_req = "R6";
        wr(3, cfg(2'b01, 2'b00, 2'b10, 2'b11));
        wr(2, 1);
        hold = 0;
        for (int i = 0; i < 18; i++) begin @(negedge clk); if (!pwm_out[1]) hold++; end
        check(hold == 0, "R6", "mode 0 output held", hold, 0);
        wr(2, 0);

        // R10: writes landing on a wrap edge
        cur_req = "R10";
        wr(3, cfg(2'b11, 2'b00, 2'b00, 2'b11));
        wr(4, 4); wr(5, 2); wr(6, 3);
        wr(2, 1);
        for (int r = 0; r < 6; r++) begin
            @(negedge clk);
            while (!(m_st == 2 && m_cnt == 0)) @(negedge clk);
            if (r % 2 == 0) wr_now(4, 2 + r);
            else            wr_now(5 + (r % 2), r);
            idle(5);
        end
        wr(2, 0);

        // R11: slow clock select
        cur_req = "R11";
        wr(4, 2); wr(5, 1);
        wr(1, 1);
        wr(2, 1);
        rise_gap(gap);
        check(gap == 12, "R11", "slow period cycles", gap, 12);
        wr(2, 0);
        wr(1, 0);

        // R3 random patterns, with mid-run updates (R10)
        cur_req = "R3";
        for (int r = 0; r < 40; r++) begin
            wr(3, cfg(2'b11, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'b11));
            wr(4, $urandom_range(0, 7));
            wr(5, $urandom_range(0, 10));
            wr(6, $urandom_range(0, 10));
            wr(2, 1);
            for (int j = 0; j < 6; j++) begin
                idle($urandom_range(1, 9));
                wr(4 + $urandom_range(0, 2), $urandom_range(0, 9));
            end
            idle(10);
            wr(2, 0);
            if (r % 10 == 9) begin
                cur_req = "R1";
                wr(0, 0);
                idle(3);
                wr(0, 1);
                cur_req = "R3";
            end
        end

        idle(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule